// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control unit of a small accumulator machine. It takes every instruction through the same subcycle plan. A fetch subcycle brings the word into the instruction register. An indirect subcycle follows only when the operand address must itself be read from memory. Next comes an execute subcycle. Last, an interrupt subcycle runs when a request is pending and enabled. All transfers go through a memory address register and a memory buffer register. These registers face a single-port synchronous memory with one cycle of read latency.

An instruction word has 16 bits: opcode in bits 15:12, indirect-mode bit in bit 11, address in bits 10:0. The opcodes are: 0 no-op, 1 load accumulator, 2 store accumulator, 3 add, 4 subtract, 5 jump, 6 branch if positive, 7 branch if zero, 8 branch if accumulator equals the index register, 9 load index register, 10 enable interrupts, 11 disable interrupts, 12 return from interrupt. Codes 13 to 15 behave as no-ops. The current subcycle state comes out as a 4-bit code, so that an observer can follow the exact order of states.

Top module: `instr_cycle_seq`

## Requirements
- R1: Every instruction begins with the fetch states 0,1,2,3. State 0 copies PC into the address register. State 1 issues the read. State 2 captures the word and increments PC by one. State 3 moves the word into the instruction register.
- R2: States 4,5,6,7 resolve the operand address through memory. They are taken only when bit 11 is set and the opcode is 1 to 9. The word read back (bits 10:0) becomes the effective address.
- R3: Execute starts in state 8. Loads, add, subtract and return-from-interrupt continue through states 9,10,11. A store continues through state 9 only. Every other opcode ends in state 8.
- R4: When an instruction ends, the block checks for an interrupt. If irq is high and the enable bit is set, it runs states 12,13,14,15. These steps decrement SP, write PC to memory at SP, load PC with the handler address (default 0x100) and clear the enable bit. Fetch then follows with no second check.
- R5: Opcode 10 sets the enable bit and opcode 11 clears it. The interrupt check at the end of an instruction uses the enable value from before that instruction changed it.
- R6: Return-from-interrupt loads PC from memory at SP, increments SP and sets the enable bit.
- R7: Only add and subtract update the flags. Sign and zero follow the result. Carry is the carry out on add and the no-borrow bit on subtract. Overflow is the signed overflow. The equal flag shows whether the two operands matched. All other opcodes leave the flags unchanged.
- R8: Jump always loads the target. Branch-if-positive is taken when sign and zero are both clear. Branch-if-zero is taken when zero is set. Branch-if-equal is taken when the accumulator equals the index register.
- R9: mem_addr always shows the address register. mem_re is high only in states 1, 5, and 9 of a read. mem_we is high only in state 9 of a store and in state 14. The two are never high together.
- R10: After reset the state is 0 and PC, SP, accumulator and flags are zero. The enable bit is clear and the supervisor bit is set.
- R11: psw_o packs the status word as bit 6 supervisor, 5 interrupt enable, 4 overflow, 3 equal, 2 carry, 1 zero, 0 sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | 11 | Memory address (address register) |
| mem_re | output | 1 | Memory read strobe, data one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rdata | input | 16 | Read data |
| state_o | output | 4 | Current subcycle state code |
| pc_o | output | 11 | Program counter |
| acc_o | output | 16 | Accumulator |
| psw_o | output | 7 | Status word |

## Verification
On every cycle the assertions check the following:
- the fetch step order and the PC increment;
- the indirect step order;
- that interrupt entry follows a cycle with irq and the enable bit both high, and lands on the handler with the enable bit cleared;
- that flags stay stable outside the arithmetic write-back state;
- the rules for which states may drive the memory strobes.

Only the bench's program run can show whether the whole state sequence of each opcode is correct. The same holds for branch outcomes under different flag values, the delay of one instruction after enabling interrupts, and the masking by the enable bit. Store, push and return data are also checked only by that run, through later reads.

// File: rtl/ics_pkg.sv
// Shared types and decode helpers for the instruction cycle sequencer.
// Assumes the 4-bit opcode field sits at the top of the instruction word.
package ics_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_NOP = 4'd0;
    localparam logic [OPC_W-1:0] OP_LDA = 4'd1;
    localparam logic [OPC_W-1:0] OP_STA = 4'd2;
    localparam logic [OPC_W-1:0] OP_ADD = 4'd3;
    localparam logic [OPC_W-1:0] OP_SUB = 4'd4;
    localparam logic [OPC_W-1:0] OP_JMP = 4'd5;
    localparam logic [OPC_W-1:0] OP_BRP = 4'd6;
    localparam logic [OPC_W-1:0] OP_BRZ = 4'd7;
    localparam logic [OPC_W-1:0] OP_BRE = 4'd8;
    localparam logic [OPC_W-1:0] OP_LDX = 4'd9;
    localparam logic [OPC_W-1:0] OP_EIN = 4'd10;
    localparam logic [OPC_W-1:0] OP_DIN = 4'd11;
    localparam logic [OPC_W-1:0] OP_RTI = 4'd12;

    typedef enum logic [3:0] {
        ST_FI_MAR, ST_FI_RD, ST_FI_MBR, ST_FI_IR,
        ST_IN_MAR, ST_IN_RD, ST_IN_MBR, ST_IN_EA,
        ST_EX_0,   ST_EX_1,  ST_EX_2,   ST_EX_3,
        ST_IT_SAVE, ST_IT_SP, ST_IT_WR, ST_IT_JMP
    } state_e;

    // Opcodes whose address field names a memory operand or branch target.
    function automatic logic uses_addr(input logic [OPC_W-1:0] op);
        return (op >= OP_LDA) && (op <= OP_LDX);
    endfunction

    // Opcodes that touch memory during execute.
    function automatic logic exec_mem(input logic [OPC_W-1:0] op);
        return (op == OP_LDA) || (op == OP_STA) || (op == OP_ADD) ||
               (op == OP_SUB) || (op == OP_LDX) || (op == OP_RTI);
    endfunction
endpackage

// File: rtl/ics_sequencer.sv
// Subcycle state machine: fetch, optional indirect, execute, optional
// interrupt. Assumes dec_* come from the buffer register in ST_FI_IR and
// ir_op holds the latched opcode from then on.
module ics_sequencer
    import ics_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq,
    input  logic             ie,
    input  logic [OPC_W-1:0] dec_op,
    input  logic             dec_ind,
    input  logic [OPC_W-1:0] ir_op,
    output state_e           state
);
    state_e nxt;
    state_e done_nxt;

    // Where an instruction goes once its last execute state is done.
    always_comb done_nxt = (irq && ie) ? ST_IT_SAVE : ST_FI_MAR;

    // Next-state selection.
    always_comb begin
        nxt = state_e'(state + 4'd1);
        case (state)
            ST_FI_IR:  nxt = (dec_ind && uses_addr(dec_op)) ? ST_IN_MAR : ST_EX_0;
            ST_EX_0:   nxt = exec_mem(ir_op) ? ST_EX_1 : done_nxt;
            ST_EX_1:   nxt = (ir_op == OP_STA) ? done_nxt : ST_EX_2;
            ST_EX_3:   nxt = done_nxt;
            ST_IT_JMP: nxt = ST_FI_MAR;
            default:   ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FI_MAR;
        else        state <= nxt;
    end
endmodule

// File: rtl/ics_alu.sv
// Add/subtract unit with status flags. Assumes unsigned carry on add and
// no-borrow carry on subtract; eq compares the raw operands.
module ics_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              f_sign,
    output logic              f_zero,
    output logic              f_carry,
    output logic              f_ovf,
    output logic              f_eq
);
    logic [DATA_W-1:0] b_eff;

    // Two's-complement arithmetic and flag derivation.
    always_comb begin
        b_eff             = sub ? ~b : b;
        {f_carry, res}    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        f_sign            = res[DATA_W-1];
        f_zero            = (res == '0);
        f_ovf             = (a[DATA_W-1] == b_eff[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
        f_eq              = (a == b);
    end
endmodule

// File: rtl/ics_branch_eval.sv
// Decides whether a jump or branch opcode loads its target.
// Assumes sign/zero are the stored flags of the last arithmetic result.
module ics_branch_eval
    import ics_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OPC_W-1:0]  op,
    input  logic              sign,
    input  logic              zero,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] xr,
    output logic              take
);
    // Condition evaluation per branch opcode.
    always_comb begin
        case (op)
            OP_JMP:  take = 1'b1;
            OP_BRP:  take = !sign && !zero;
            OP_BRZ:  take = zero;
            OP_BRE:  take = (acc == xr);
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/instr_cycle_seq.sv
// Control unit and register file of a small accumulator machine. It moves
// data among PC, MAR, MBR, IR, ACC, X and SP over a memory port with
// one cycle of read latency. Assumes mem_rdata is valid the cycle after mem_re.
module instr_cycle_seq
    import ics_pkg::*;
#(
    parameter int                ADDR_W  = 11,
    parameter logic [ADDR_W-1:0] HANDLER = 'h100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    irq,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_re,
    output logic                    mem_we,
    output logic [ADDR_W+4:0]       mem_wdata,
    input  logic [ADDR_W+4:0]       mem_rdata,
    output logic [3:0]              state_o,
    output logic [ADDR_W-1:0]       pc_o,
    output logic [ADDR_W+4:0]       acc_o,
    output logic [6:0]              psw_o
);
    localparam int DATA_W = ADDR_W + 1 + OPC_W;
    localparam int IND_B  = ADDR_W;

    state_e            state;
    logic [ADDR_W-1:0] pc, mar, ea, sp, ir_addr;
    logic [DATA_W-1:0] mbr, acc, xr, alu_res;
    logic [OPC_W-1:0]  ir_op;
    logic              fl_s, fl_z, fl_c, fl_v, fl_e, ie;
    logic              a_s, a_z, a_c, a_v, a_e, take;

    ics_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .irq(irq), .ie(ie),
        .dec_op(mbr[DATA_W-1 -: OPC_W]), .dec_ind(mbr[IND_B]),
        .ir_op(ir_op), .state(state)
    );

    ics_alu #(.DATA_W(DATA_W)) u_alu (
        .a(acc), .b(mbr), .sub(ir_op == OP_SUB), .res(alu_res),
        .f_sign(a_s), .f_zero(a_z), .f_carry(a_c), .f_ovf(a_v), .f_eq(a_e)
    );

    ics_branch_eval #(.DATA_W(DATA_W)) u_br (
        .op(ir_op), .sign(fl_s), .zero(fl_z), .acc(acc), .xr(xr), .take(take)
    );

    // Register transfers for each subcycle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; mar <= '0; ea <= '0; sp <= '0; ir_addr <= '0;
            mbr <= '0; acc <= '0; xr <= '0; ir_op <= OP_NOP;
            {fl_s, fl_z, fl_c, fl_v, fl_e, ie} <= '0;
        end else begin
            case (state)
                ST_FI_MAR: mar <= pc;
                ST_FI_MBR: begin mbr <= mem_rdata; pc <= pc + 1'b1; end
                ST_FI_IR: begin
                    ir_op   <= mbr[DATA_W-1 -: OPC_W];
                    ir_addr <= mbr[ADDR_W-1:0];
                    ea      <= mbr[ADDR_W-1:0];
                end
                ST_IN_MAR: mar <= ir_addr;
                ST_IN_MBR: mbr <= mem_rdata;
                ST_IN_EA:  ea  <= mbr[ADDR_W-1:0];
                ST_EX_0: begin
                    if (ir_op == OP_STA) mbr <= acc;
                    if (ir_op == OP_RTI) mar <= sp;
                    else if (exec_mem(ir_op)) mar <= ea;
                    if (take) pc <= ea;
                    if (ir_op == OP_EIN) ie <= 1'b1;
                    if (ir_op == OP_DIN) ie <= 1'b0;
                end
                ST_EX_2: mbr <= mem_rdata;
                ST_EX_3: begin
                    case (ir_op)
                        OP_LDA: acc <= mbr;
                        OP_LDX: xr  <= mbr;
                        OP_ADD, OP_SUB: begin
                            acc <= alu_res;
                            {fl_s, fl_z, fl_c, fl_v, fl_e} <= {a_s, a_z, a_c, a_v, a_e};
                        end
                        OP_RTI: begin
                            pc <= mbr[ADDR_W-1:0]; sp <= sp + 1'b1; ie <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_IT_SAVE: begin mbr <= DATA_W'(pc); sp <= sp - 1'b1; end
                ST_IT_SP:   mar <= sp;
                ST_IT_JMP:  begin pc <= HANDLER; ie <= 1'b0; end
                default: ;
            endcase
        end
    end

    // Memory strobes and observation outputs.
    always_comb begin
        mem_addr  = mar;
        mem_wdata = mbr;
        mem_re    = (state == ST_FI_RD) || (state == ST_IN_RD) ||
                    ((state == ST_EX_1) && (ir_op != OP_STA));
        mem_we    = ((state == ST_EX_1) && (ir_op == OP_STA)) || (state == ST_IT_WR);
        state_o   = state;
        pc_o      = pc;
        acc_o     = acc;
        psw_o     = {1'b1, ie, fl_v, fl_e, fl_c, fl_z, fl_s};
    end
endmodule

// File: rtl/instr_cycle_seq_checker.sv
// Cycle-level properties of the sequencer, attached by bind.
module instr_cycle_seq_checker #(
    parameter int                ADDR_W  = 11,
    parameter logic [ADDR_W-1:0] HANDLER = 'h100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              mem_re,
    input logic              mem_we,
    input logic [3:0]        state_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [6:0]        psw_o
);
    AST_FETCH_STEP_A: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd0 |=> state_o == 4'd1); // R1
    AST_FETCH_STEP_B: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd1 |=> state_o == 4'd2); // R1
    AST_FETCH_STEP_C: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd2 |=> state_o == 4'd3); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd2 |=> pc_o == ADDR_W'($past(pc_o) + 1'b1)); // R1
    AST_IND_STEP: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd4 |=> state_o == 4'd5); // R2
    AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n) (state_o == 4'd12) |-> ($past(irq) && $past(psw_o[5]))); // R4
    AST_INT_TARGET: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd15 |=> (pc_o == HANDLER) && !psw_o[5]); // R4
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n) state_o != 4'd11 |=> $stable(psw_o[4:0])); // R7
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we)); // R9
    AST_WE_WHERE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (state_o == 4'd9 || state_o == 4'd14)); // R9
    AST_RE_WHERE: assert property (@(posedge clk) disable iff (!rst_n) mem_re |-> (state_o == 4'd1 || state_o == 4'd5 || state_o == 4'd9)); // R9
    AST_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n) psw_o[6]); // R10
endmodule

bind instr_cycle_seq instr_cycle_seq_checker #(.ADDR_W(ADDR_W), .HANDLER(HANDLER)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_re(mem_re), .mem_we(mem_we),
    .state_o(state_o), .pc_o(pc_o), .psw_o(psw_o)
);

// File: tb/instr_cycle_seq_bench.sv
// Program-driven bench: a behavioural instruction model predicts the state
// code of every cycle and the architectural state at every instruction edge.
module instr_cycle_seq_bench;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam logic [AW-1:0] HND = 11'h100;

    logic clk = 1'b0, rst_n = 1'b0, irq = 1'b0, irq_q = 1'b0;
    logic [AW-1:0] mem_addr, pc_o;
    logic mem_re, mem_we;
    logic [DW-1:0] mem_wdata, acc_o;
    logic [DW-1:0] mem_rdata = '0;
    logic [3:0] state_o;
    logic [6:0] psw_o;

    always #5 clk = ~clk;

    instr_cycle_seq #(.ADDR_W(AW), .HANDLER(HND)) u_instr_cycle_seq (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .state_o(state_o), .pc_o(pc_o), .acc_o(acc_o), .psw_o(psw_o)
    );

    logic [DW-1:0] mem [2**AW];
    logic [DW-1:0] mm  [2**AW];
    int checks = 0, fails = 0, cycles = 0, int_entries = 0;
    bit running = 0, finished = 0;

    // Memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
        irq_q <= irq;
        cycles <= cycles + 1;
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // Model state.
    int exp_q[$];
    logic [AW-1:0] m_pc = '0, m_sp = '0;
    logic [DW-1:0] m_acc = '0, m_x = '0;
    logic m_s = 0, m_z = 0, m_c = 0, m_v = 0, m_e = 0, m_ie = 0, m_ie_before = 0;
    bit last_instr = 0;

    function automatic logic [6:0] m_psw();
        return {1'b1, m_ie, m_v, m_e, m_c, m_z, m_s};  // R11 layout
    endfunction

    task automatic model_alu(input logic [DW-1:0] b, input bit sub);
        logic [DW:0] s;
        logic [DW-1:0] be;
        be = sub ? ~b : b;
        s = {1'b0, m_acc} + {1'b0, be} + (sub ? 17'd1 : 17'd0);
        m_e = (m_acc == b);
        m_v = (m_acc[DW-1] == be[DW-1]) && (s[DW-1] != m_acc[DW-1]);
        m_c = s[DW];
        m_acc = s[DW-1:0];
        m_s = m_acc[DW-1];
        m_z = (m_acc == '0);
    endtask

    // Instruction boundary: compare architecture, then predict the next sequence.
    task automatic boundary();
        logic [DW-1:0] ins;
        logic [3:0] op;
        logic [AW-1:0] ea;
        check("R1/R8 pc", pc_o, m_pc);
        check("R7 acc", acc_o, m_acc);
        check("R7/R11 psw", psw_o, m_psw());
        if (last_instr && irq_q && m_ie_before) begin
            // R4 interrupt entry
            exp_q.push_back(12); exp_q.push_back(13); exp_q.push_back(14); exp_q.push_back(15);
            m_sp = m_sp - 1'b1;
            mm[m_sp] = DW'(m_pc);
            m_pc = HND;
            m_ie = 0;
            last_instr = 0;
            return;
        end
        ins = mm[m_pc]; op = ins[15:12]; ea = ins[AW-1:0];
        for (int i = 0; i < 4; i++) exp_q.push_back(i);     // R1
        m_pc = m_pc + 1'b1;
        if (ins[11] && op >= 1 && op <= 9) begin            // R2
            for (int i = 4; i < 8; i++) exp_q.push_back(i);
            ea = mm[ea][AW-1:0];
        end
        m_ie_before = m_ie;
        exp_q.push_back(8);                                 // R3
        case (op)
            1: begin exp_q.push_back(9); exp_q.push_back(10); exp_q.push_back(11); m_acc = mm[ea]; end
            2: begin exp_q.push_back(9); mm[ea] = m_acc; end
            3: begin exp_q.push_back(9); exp_q.push_back(10); exp_q.push_back(11); model_alu(mm[ea], 0); end
            4: begin exp_q.push_back(9); exp_q.push_back(10); exp_q.push_back(11); model_alu(mm[ea], 1); end
            5: m_pc = ea;                                   // R8
            6: if (!m_s && !m_z) m_pc = ea;
            7: if (m_z) m_pc = ea;
            8: if (m_acc == m_x) m_pc = ea;
            9: begin exp_q.push_back(9); exp_q.push_back(10); exp_q.push_back(11); m_x = mm[ea]; end
            10: m_ie = 1;                                   // R5
            11: m_ie = 0;
            12: begin                                       // R6
                exp_q.push_back(9); exp_q.push_back(10); exp_q.push_back(11);
                m_pc = mm[m_sp][AW-1:0]; m_sp = m_sp + 1'b1; m_ie = 1;
            end
            default: ;
        endcase
        last_instr = 1;
    endtask

    // Per-cycle comparison of the state code.
    always @(negedge clk) begin
        if (running && rst_n) begin
            int e;
            if (exp_q.size() == 0) boundary();
            e = exp_q.pop_front();
            check("R1/R2/R3/R4 state", state_o, e);
            if (state_o == 4'd12) int_entries++;
        end
    end

    function automatic logic [15:0] enc(input int op, input int ind, input int a);
        return {op[3:0], ind[0], a[10:0]};
    endfunction

    task automatic put(input int a, input logic [15:0] w);
        mem[a] = w; mm[a] = w;
    endtask

    task automatic finish_run();
        if (finished) return;
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2**AW; i++) begin mem[i] = '0; mm[i] = '0; end
        put('h40, 16'h7FFF); put('h41, 16'h0001); put('h42, 16'h0043);
        put('h43, 16'h1234); put('h44, 16'h8000); put('h45, 16'h0005);
        put('h00, enc(1, 0, 'h40));  // load 7FFF
        put('h01, enc(3, 0, 'h41));  // add -> 8000, overflow (R7)
        put('h02, enc(6, 0, 'h05));  // branch positive: not taken (R8)
        put('h03, enc(4, 0, 'h44));  // sub -> 0, carry, equal
        put('h04, enc(7, 0, 'h06));  // branch zero: taken
        put('h05, enc(1, 0, 'h41));  // skipped
        put('h06, enc(1, 1, 'h42));  // indirect load -> 1234 (R2)
        put('h07, enc(2, 0, 'h46));  // store
        put('h08, enc(9, 0, 'h46));  // load X from stored word
        put('h09, enc(8, 0, 'h0B));  // branch equal: taken
        put('h0A, enc(0, 0, 0));
        put('h0B, enc(10, 0, 0));    // enable interrupts (R5)
        put('h0C, enc(1, 0, 'h45));  // load 5, flags untouched
        put('h0D, enc(6, 0, 'h0F));
        put('h0E, enc(4, 0, 'h41));
        put('h0F, enc(6, 0, 'h11));
        put('h10, enc(0, 1, 'h41));  // no-op with indirect bit: no indirect
        put('h11, enc(11, 0, 0));    // disable interrupts
        put('h12, enc(5, 0, 'h12));  // park loop
        put('h100, enc(3, 0, 'h41)); // handler: add 1
        put('h101, enc(12, 0, 0));   // return (R6)

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset values while reset is held
        check("R10 state", state_o, 0);
        check("R10 pc", pc_o, 0);
        check("R10 acc", acc_o, 0);
        check("R10/R11 psw", psw_o, 7'b1000000);
        check("R9 strobes idle", {mem_re, mem_we}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        running = 1;
        // irq raised while enable is clear: masked until enabled (R5)
        repeat (20) @(negedge clk);
        irq = 1'b1;
        while (state_o != 4'd15) @(negedge clk);
        irq = 1'b0;
        // request after disable: ignored (R4)
        while (cycles < 400) @(negedge clk);
        irq = 1'b1;
        repeat (200) @(negedge clk);
        irq = 1'b0;
        repeat (20) @(negedge clk);
        running = 0;
        check("R4 one interrupt entry", int_entries, 1);
        check("R4 pushed return address", mem[11'h7FF], mm[11'h7FF]);
        check("R3 stored word", mem['h46], 16'h1234);
        finish_run();
    end
endmodule